// File: doc/BRIEF.md
# Processor Reset Generator with Cause Capture

This block drives power-on reset and externally initiated reset lines to the processors of a four-processor node. Software controls it through a small byte-wide register file with one write port and a combinational read port. A write to the soft power-on register requests reset for chosen processors or for the whole system. A write to the soft external-reset register requests an external reset for chosen processors. The block also turns several inputs into resets: a watchdog expiry that software must enable, a push-button, a JTAG-style request and a clock-synthesizer load.

Every reset output is stretched to a fixed 16-clock pulse. Two status registers record what happened: a 17-bit power-on cause register and a 6-bit external-reset source register. Software reads them after the node comes back up. Each new event replaces the old contents with that event's bits, so the registers always describe the most recent reset.

Register map (3-bit address): 0 soft power-on request, 1 soft external-reset request, 2 watchdog action, 3 synthesizer control, 4/5/6 cause bits 7:0, 15:8 and 16 (in bit 0), 7 external-reset source. Writes to addresses 4 to 7 have no effect. Reserved bits read as zero.

Top module: `rstgen_top`

## Requirements
- R1: While `rst_ni` is low and after its release, all reset outputs are low and the soft, watchdog-action and synthesizer registers read 0. The cause register reads only bit 7 (power-up, value 0x80). The external-reset source reads 0.
- R2: Bits 3:0 of a write to address 0 are requests for processors 3 to 0. A request made at edge k raises that processor's `por_o` bit from edge k+1 for exactly 16 clocks and leaves the other processors untouched. The cause register then reads bit n for processor n.
- R3: Bit 4 of a write to address 0 is a system reset. It drives `sys_por_o` and all four `por_o` bits for 16 clocks, and the cause register reads bit 4 alone.
- R4: A soft request bit reads back as set until the pulse is issued and reads 0 from the next edge onward.
- R5: Bits 3:0 of a write to address 1 drive the matching `xir_o` bits for 16 clocks, set the same bits of the external-reset source register, and leave the power-on cause unchanged.
- R6: When bit 0 of address 2 is set, a cycle with `wdog_i` high causes a system reset with cause bit 16. When that bit is clear, `wdog_i` has no effect on the outputs or on the cause register.
- R7: The synthesizer control register at address 3 has a reset-enable bit (bit 7) and a load bit (bit 0). When both bits become set together, the block issues one system reset with cause bit 15. The load bit alone causes no reset.
- R8: `jtag_por_i` causes a system reset with cause bit 5. `btn_por_i` causes a system reset with cause bit 6.
- R9: `jtag_xir_i` drives all four `xir_o` bits and the source register reads bit 4. `btn_xir_i` does the same with bit 5.
- R10: A new event overwrites the cause or source register with only its own bits. Events in the same cycle OR their bits together.
- R11: A new request for an output that is already pulsing restarts its count, so the output stays high until 16 clocks after the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| wdog_i | input | 1 | Watchdog expiry, one event per high cycle |
| btn_por_i | input | 1 | Push-button system reset request |
| btn_xir_i | input | 1 | Push-button external reset request |
| jtag_por_i | input | 1 | JTAG-style system reset request |
| jtag_xir_i | input | 1 | JTAG-style external reset request |
| por_o | output | 4 | Per-processor power-on reset |
| sys_por_o | output | 1 | System reset |
| xir_o | output | 4 | Per-processor external reset |

## Verification
The bench applies several kinds of input. Single-bit soft writes show that each processor line is independent. The system bit shows the fan-out to every processor. Each external source is tried alone, so a wrong cause bit position cannot hide. The watchdog is pulsed with its enable both clear and set, which separates the gated path from an ungated one. The synthesizer load bit is tried alone and then with the enable bit, which separates an AND from an OR. Two simultaneous sources, and a soft write followed one cycle later by a JTAG request, separate OR-merging from last-writer-wins. A repeated button press during a pulse separates restart from ignoring the new request.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int N_CPU     = 4;
  localparam int PULSE_LEN = 16;
  localparam int CNT_W     = $clog2(PULSE_LEN + 1);
  localparam int ADDR_W    = 3;
  localparam int CAUSE_W   = 17;
  localparam int XSRC_W    = 6;

  localparam logic [ADDR_W-1:0] A_SOFT_POR = 3'd0;
  localparam logic [ADDR_W-1:0] A_SOFT_XIR = 3'd1;
  localparam logic [ADDR_W-1:0] A_WD_ACT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SYNTH    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAUSE_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAUSE_MD = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAUSE_HI = 3'd6;
  localparam logic [ADDR_W-1:0] A_XSRC     = 3'd7;

  localparam logic [7:0] M_SOFT_POR = 8'h1f;
  localparam logic [7:0] M_SOFT_XIR = 8'h0f;
  localparam logic [7:0] M_WD_ACT   = 8'h01;
  localparam logic [7:0] M_SYNTH    = 8'h81;

  localparam logic [CAUSE_W-1:0] CAUSE_PWRUP = 17'h00080;
endpackage

// File: rtl/rstgen_regs.sv
module rstgen_regs
  import rstgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        soft_por_o,
  output logic [7:0]        soft_xir_o,
  output logic [7:0]        wd_act_o,
  output logic [7:0]        synth_o,
  output logic              synth_evt_o
);
  logic synth_arm_q;
  logic synth_cond;

  assign synth_cond  = synth_o[7] & synth_o[0];
  assign synth_evt_o = synth_cond & ~synth_arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_por_o  <= '0;
      soft_xir_o  <= '0;
      wd_act_o    <= '0;
      synth_o     <= '0;
      synth_arm_q <= 1'b0;
    end else begin
      // soft requests are consumed the cycle after they are written
      soft_por_o  <= (wr_en_i && addr_i == A_SOFT_POR) ? (wdata_i & M_SOFT_POR) : '0;
      soft_xir_o  <= (wr_en_i && addr_i == A_SOFT_XIR) ? (wdata_i & M_SOFT_XIR) : '0;
      if (wr_en_i && addr_i == A_WD_ACT) wd_act_o <= wdata_i & M_WD_ACT;
      if (wr_en_i && addr_i == A_SYNTH)  synth_o  <= wdata_i & M_SYNTH;
      synth_arm_q <= synth_cond;
    end
  end
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch
  import rstgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CPU-1:0]   soft_cpu_i,
  input  logic               soft_sys_i,
  input  logic               jtag_por_i,
  input  logic               btn_por_i,
  input  logic               synth_i,
  input  logic               wdog_i,
  input  logic [N_CPU-1:0]   soft_xir_i,
  input  logic               jtag_xir_i,
  input  logic               btn_xir_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XSRC_W-1:0]  xsrc_o
);
  logic [CAUSE_W-1:0] cause_d;
  logic [XSRC_W-1:0]  xsrc_d;

  assign cause_d = {wdog_i, synth_i, 7'b0, 1'b0, btn_por_i, jtag_por_i, soft_sys_i, soft_cpu_i};
  assign xsrc_d  = {btn_xir_i, jtag_xir_i, soft_xir_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= CAUSE_PWRUP;
      xsrc_o  <= '0;
    end else begin
      if (cause_d != '0) cause_o <= cause_d;
      if (xsrc_d  != '0) xsrc_o  <= xsrc_d;
    end
  end
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        wdog_i,
  input  logic        btn_por_i,
  input  logic        btn_xir_i,
  input  logic        jtag_por_i,
  input  logic        jtag_xir_i,
  output logic [3:0]  por_o,
  output logic        sys_por_o,
  output logic [3:0]  xir_o
);
  logic [7:0]         soft_por_q, soft_xir_q, wd_act_q, synth_q;
  logic               synth_evt;
  logic               wdog_evt;
  logic               sys_evt;
  logic               wr_soft;
  logic [CAUSE_W-1:0] cause_q;
  logic [XSRC_W-1:0]  xsrc_q;

  rstgen_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .soft_por_o  (soft_por_q),
    .soft_xir_o  (soft_xir_q),
    .wd_act_o    (wd_act_q),
    .synth_o     (synth_q),
    .synth_evt_o (synth_evt)
  );

  assign wdog_evt = wdog_i & wd_act_q[0];
  assign sys_evt  = soft_por_q[N_CPU] | jtag_por_i | btn_por_i | synth_evt | wdog_evt;
  assign wr_soft  = wr_en_i && (addr_i == A_SOFT_POR);

  rstgen_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_cpu_i (soft_por_q[N_CPU-1:0]),
    .soft_sys_i (soft_por_q[N_CPU]),
    .jtag_por_i (jtag_por_i),
    .btn_por_i  (btn_por_i),
    .synth_i    (synth_evt),
    .wdog_i     (wdog_evt),
    .soft_xir_i (soft_xir_q[N_CPU-1:0]),
    .jtag_xir_i (jtag_xir_i),
    .btn_xir_i  (btn_xir_i),
    .cause_o    (cause_q),
    .xsrc_o     (xsrc_q)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    rstgen_stretch u_por (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (soft_por_q[i] | sys_evt),
      .active_o (por_o[i])
    );
    rstgen_stretch u_xir (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (soft_xir_q[i] | jtag_xir_i | btn_xir_i),
      .active_o (xir_o[i])
    );
  end

  rstgen_stretch u_sys (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (sys_evt),
    .active_o (sys_por_o)
  );

  always_comb begin
    unique case (addr_i)
      A_SOFT_POR: rdata_o = soft_por_q;
      A_SOFT_XIR: rdata_o = soft_xir_q;
      A_WD_ACT:   rdata_o = wd_act_q;
      A_SYNTH:    rdata_o = synth_q;
      A_CAUSE_LO: rdata_o = cause_q[7:0];
      A_CAUSE_MD: rdata_o = cause_q[15:8];
      A_CAUSE_HI: rdata_o = {7'b0, cause_q[16]};
      default:    rdata_o = {2'b0, xsrc_q};
    endcase
  end
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  por_o,
  input logic        sys_por_o,
  input logic [3:0]  xir_o,
  input logic [16:0] cause_i,
  input logic [5:0]  xsrc_i,
  input logic [7:0]  soft_por_i,
  input logic        wr_soft_i
);
  AST_SYS_FANOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_por_o |-> (por_o == 4'hf)); // R3
  AST_SOFT_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_por_i != 8'h0 && !wr_soft_i) |=> (soft_por_i == 8'h0)); // R4
  AST_POR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_o[0]) |-> ((cause_i & 17'h18071) != 17'h0)); // R2
  AST_XIR_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xir_o[1]) |-> ((xsrc_i & 6'h32) != 6'h0)); // R5
  AST_PULSE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_por_o) |=> sys_por_o); // R11
endmodule

bind rstgen_top rstgen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_o      (por_o),
  .sys_por_o  (sys_por_o),
  .xir_o      (xir_o),
  .cause_i    (cause_q),
  .xsrc_i     (xsrc_q),
  .soft_por_i (soft_por_q),
  .wr_soft_i  (wr_soft)
);

// File: tb/rstgen_top_tb_top.sv
`timescale 1ns/1ps
module rstgen_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic wdog = 1'b0, btn_por = 1'b0, btn_xir = 1'b0, jtag_por = 1'b0, jtag_xir = 1'b0;
  logic [7:0] rdata;
  logic [3:0] por, xir;
  logic sys_por;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstgen_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wdog_i(wdog), .btn_por_i(btn_por), .btn_xir_i(btn_xir),
    .jtag_por_i(jtag_por), .jtag_xir_i(jtag_xir), .por_o(por), .sys_por_o(sys_por),
    .xir_o(xir)
  );

  // behavioural reference
  int m_sp, m_sx, m_wd, m_syn, m_cause, m_xsrc;
  bit m_syn_prev;
  int m_cp[4];
  int m_cx[4];
  int m_cs;
  int ev_cause, ev_xsrc;
  bit ev_sys, syn_now;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = 0; m_sx = 0; m_wd = 0; m_syn = 0; m_syn_prev = 0;
      m_cause = 'h80; m_xsrc = 0; m_cs = 0;
      for (int i = 0; i < 4; i++) begin m_cp[i] = 0; m_cx[i] = 0; end
    end else begin
      syn_now  = (m_syn & 'h81) == 'h81;
      ev_cause = (m_sp & 'h1f) | (jtag_por << 5) | (btn_por << 6)
               | ((syn_now && !m_syn_prev) << 15) | ((wdog && (m_wd & 1)) << 16);
      ev_sys   = (ev_cause & ~'hf) != 0;
      ev_xsrc  = (m_sx & 'hf) | (jtag_xir << 4) | (btn_xir << 5);
      for (int i = 0; i < 4; i++) begin
        if (ev_sys || ((m_sp >> i) & 1)) m_cp[i] = 16; else if (m_cp[i] > 0) m_cp[i]--;
        if (jtag_xir || btn_xir || ((m_sx >> i) & 1)) m_cx[i] = 16; else if (m_cx[i] > 0) m_cx[i]--;
      end
      if (ev_sys) m_cs = 16; else if (m_cs > 0) m_cs--;
      if (ev_cause != 0) m_cause = ev_cause;
      if (ev_xsrc != 0) m_xsrc = ev_xsrc;
      m_syn_prev = syn_now;
      m_sp = (wr_en && addr == 0) ? (wdata & 'h1f) : 0;
      m_sx = (wr_en && addr == 1) ? (wdata & 'h0f) : 0;
      if (wr_en && addr == 2) m_wd = wdata & 'h01;
      if (wr_en && addr == 3) m_syn = wdata & 'h81;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_sp;
      1: return m_sx;
      2: return m_wd;
      3: return m_syn;
      4: return m_cause & 'hff;
      5: return (m_cause >> 8) & 'hff;
      6: return (m_cause >> 16) & 1;
      default: return m_xsrc;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        chk("R2 por_o", int'(por[i]), int'(m_cp[i] > 0));
        chk("R5 xir_o", int'(xir[i]), int'(m_cx[i] > 0));
      end
      chk("R3 sys_por_o", int'(sys_por), int'(m_cs > 0));
      chk("R10 rdata", int'(rdata), exp_rd(int'(addr)));
    end
  end

  task automatic wr(input int a, input int d);
    addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag, input int exp);
    addr = 3'(a);
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 por_o", int'(por), 0);
    chk("R1 sys_por_o", int'(sys_por), 0);
    rd(4, "R1 cause", 'h80);
    rd(7, "R1 xsrc", 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, "R1 soft", 0);
    rd(4, "R1 cause after release", 'h80);

    // R2 / R4 single processor soft reset
    wr(0, 'h02);
    rd(0, "R4 pending", 'h02);
    @(negedge clk);
    rd(0, "R4 self-clear", 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 por_o high", int'(por), 'h2);
      @(negedge clk);
    end
    chk("R2 por_o released", int'(por), 0);
    rd(4, "R2 cause", 'h02);

    // R3 system soft reset
    wr(0, 'h10);
    @(negedge clk);
    chk("R3 sys", int'(sys_por), 1);
    chk("R3 fanout", int'(por), 'hf);
    repeat (18) @(negedge clk);
    rd(4, "R3 cause", 'h10);
    rd(5, "R3 cause mid", 0);

    // R5 soft external reset
    wr(1, 'h05);
    @(negedge clk);
    chk("R5 xir", int'(xir), 'h5);
    rd(7, "R5 xsrc", 'h05);
    rd(4, "R5 cause kept", 'h10);
    repeat (18) @(negedge clk);

    // R6 watchdog gated off, then on
    pulse_in(wdog);
    chk("R6 ignored sys", int'(sys_por), 0);
    rd(4, "R6 ignored cause", 'h10);
    wr(2, 'h01);
    pulse_in(wdog);
    chk("R6 wdog sys", int'(sys_por), 1);
    rd(6, "R6 cause", 1);
    rd(4, "R6 cause lo", 0);
    repeat (18) @(negedge clk);

    // R7 synthesizer
    wr(3, 'h01);
    repeat (3) @(negedge clk);
    chk("R7 load alone", int'(sys_por), 0);
    wr(3, 'h81);
    @(negedge clk);
    chk("R7 synth sys", int'(sys_por), 1);
    rd(5, "R7 cause", 'h80);
    wr(3, 'h00);
    repeat (18) @(negedge clk);

    // R8 jtag and button power-on
    pulse_in(jtag_por);
    chk("R8 jtag sys", int'(sys_por), 1);
    rd(4, "R8 jtag cause", 'h20);
    repeat (18) @(negedge clk);
    pulse_in(btn_por);
    rd(4, "R8 button cause", 'h40);
    rd(6, "R8 button cause hi", 0);
    repeat (18) @(negedge clk);

    // R9 jtag and button external
    pulse_in(jtag_xir);
    chk("R9 jtag xir", int'(xir), 'hf);
    rd(7, "R9 jtag src", 'h10);
    repeat (18) @(negedge clk);
    pulse_in(btn_xir);
    rd(7, "R9 button src", 'h20);
    repeat (18) @(negedge clk);

    // R10 simultaneous events merge
    jtag_por = 1'b1; btn_por = 1'b1;
    @(negedge clk);
    jtag_por = 1'b0; btn_por = 1'b0;
    rd(4, "R10 merged cause", 'h60);
    wr(1, 'h02);
    pulse_in(jtag_xir);
    rd(7, "R10 merged src", 'h12);
    repeat (18) @(negedge clk);

    // R11 retrigger
    pulse_in(btn_por);
    repeat (10) @(negedge clk);
    pulse_in(btn_por);
    for (int i = 0; i < 16; i++) begin
      chk("R11 extended", int'(sys_por), 1);
      @(negedge clk);
    end
    chk("R11 released", int'(sys_por), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule